// File: doc/BRIEF.md
# Configurable Boundary-Scan Cell Chain

This block is the serial register that sits between a chip's pads and its core logic for board-level test. It is one chain of cells, and a parameter array sets the kind and the position of every cell. There are four kinds:

- a full input cell;
- a read-only input cell, which only observes;
- an output data cell;
- an output-enable cell, which also drives a pull-up disable.

Every cell has a capture/shift flop clocked on the rising edge of the test clock. Every cell except the read-only one also has an update flop that loads on the falling edge. A test-mode select picks, for each cell, either the functional value or the held update value.

The test access controller lives outside this block and supplies four strobes: capture, shift, update and test mode. A scan sequence runs in four steps. First, capture samples every cell's functional input. Second, shift moves the data one cell toward the serial output on each clock. Third, update copies the shifted pattern into the update flops. Fourth, once test mode is set, that pattern drives the pads or the core in place of the functional values.

Top module: `bscan_chain`

## Requirements
- R1: While rst_n is low at a rising edge, every update flop clears to 0. With test_mode at 1 after reset, the output of every full input, output data and output-enable cell is therefore 0, which is the tristated value for an enable. The pull-up disable of every output-enable cell is also 0.
- R2: When cap_dr is 1 at a rising edge, every cell's capture/shift flop loads that cell's func_in bit.
- R3: When shift_dr is 1 and cap_dr is 0 at a rising edge, cell 0 loads scan_in and each cell i>0 loads the old value of cell i-1. scan_out always shows the flop of cell NCELLS-1.
- R4: Update flops load the capture/shift value only on a falling edge while upd_dr is 1. While upd_dr is 0, func_out stays unchanged during shifting.
- R5: When test_mode is 0, func_out equals func_in and pull_out equals pull_in on every bit.
- R6: When test_mode is 1, func_out of every full input, output data and output-enable cell equals that cell's update flop.
- R7: A read-only input cell (kind code 1) always passes func_in to func_out, whatever test_mode and the scan contents are.
- R8: When test_mode is 1, pull_out of an output-enable cell (kind code 3) equals its update flop. Every other cell passes pull_in to pull_out.
- R9: When cap_dr and shift_dr are both 0 at a rising edge, the capture/shift flops hold their values.
- R10: When cap_dr and shift_dr are both 1 at a rising edge, capture takes precedence over shift.

The kind codes are: 0 for a full input cell, 1 for a read-only input cell, 2 for an output data cell and 3 for an output-enable cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_dr | input | 1 | Capture strobe |
| shift_dr | input | 1 | Shift strobe |
| upd_dr | input | 1 | Update strobe, acted on at the falling edge |
| test_mode | input | 1 | 1 selects the update flops over the functional path |
| scan_in | input | 1 | Serial data into cell 0 |
| scan_out | output | 1 | Serial data from cell NCELLS-1 |
| func_in | input | NCELLS | Functional value per cell: a pad input, or a core data or enable output |
| func_out | output | NCELLS | Value per cell toward the core or the pad |
| pull_in | input | NCELLS | Core pull-up disable per cell |
| pull_out | output | NCELLS | Pull-up disable per cell toward the pad |

## Verification
A capture or shift result shows on scan_out one rising edge after the strobe. The bench therefore samples scan_out one time unit after that edge, and reads each serial bit before the edge that shifts it on. An update becomes visible on func_out after the falling edge in the middle of the cycle in which upd_dr is high. The bench raises upd_dr just after a rising edge and checks func_out after the next rising edge. The mode multiplexers are combinational, so after test_mode changes, the outputs are checked one time unit later and no clock edge is needed.

// File: rtl/bsc_pkg.sv
// Shared definitions for the boundary-scan chain: cell kinds and the
// default chain layout used when the top is elaborated alone.
package bsc_pkg;

    typedef enum logic [1:0] {
        KIND_IN    = 2'd0,
        KIND_IN_RO = 2'd1,
        KIND_OUT   = 2'd2,
        KIND_OE    = 2'd3
    } cell_kind_e;

    localparam int unsigned DEF_NCELLS = 8;

    localparam cell_kind_e DEF_KINDS [DEF_NCELLS] = '{
        KIND_IN, KIND_IN_RO, KIND_OUT, KIND_OE,
        KIND_IN, KIND_OUT,   KIND_OE,  KIND_IN_RO
    };

endpackage

// File: rtl/bsc_shift_stage.sv
// Capture/shift flop of one cell.
// Assumes: strobes are stable around the rising edge; capture beats shift.
module bsc_shift_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic cap_en,
    input  logic shift_en,
    input  logic ser_in,
    input  logic cap_val,
    output logic q
);
    // Load on capture, move on shift, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)        q <= 1'b0;
        else if (cap_en)   q <= cap_val;
        else if (shift_en) q <= ser_in;
    end
endmodule

// File: rtl/bsc_update_latch.sv
// Update stage of one cell, loaded on the falling edge so that the value
// driven under test mode never moves while data is shifting.
// Assumes: rst_n and upd_en change only just after a rising edge.
module bsc_update_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic upd_en,
    input  logic d,
    output logic q
);
    // Clear on reset, copy the shift stage when update is strobed.
    always_ff @(negedge clk) begin
        if (!rst_n)      q <= 1'b0;
        else if (upd_en) q <= d;
    end
endmodule

// File: rtl/bsc_cell.sv
// One boundary-scan cell; KIND selects the variant built by generate.
// Assumes: the read-only kind has no update stage and never overrides.
module bsc_cell
    import bsc_pkg::*;
#(
    parameter cell_kind_e KIND = KIND_IN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cap_en,
    input  logic shift_en,
    input  logic upd_en,
    input  logic mode,
    input  logic ser_in,
    input  logic func_in,
    input  logic pull_in,
    output logic ser_out,
    output logic func_out,
    output logic pull_out,
    output logic upd_val
);
    logic sh_q;

    bsc_shift_stage u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .shift_en (shift_en),
        .ser_in   (ser_in),
        .cap_val  (func_in),
        .q        (sh_q)
    );

    assign ser_out = sh_q;

    generate
        if (KIND == KIND_IN_RO) begin : g_ro
            logic unused_ok;
            // Observe only: the functional path is a plain wire.
            assign unused_ok = upd_en ^ mode;
            assign upd_val   = 1'b0;
            assign func_out  = func_in;
            assign pull_out  = pull_in;
        end else begin : g_upd
            logic upd_q;
            bsc_update_latch u_upd (
                .clk    (clk),
                .rst_n  (rst_n),
                .upd_en (upd_en),
                .d      (sh_q),
                .q      (upd_q)
            );
            assign upd_val  = upd_q;
            // Mode mux toward pad or core.
            assign func_out = mode ? upd_q : func_in;
            if (KIND == KIND_OE) begin : g_pull
                // The enable cell also owns the pull-up disable.
                assign pull_out = mode ? upd_q : pull_in;
            end else begin : g_nopull
                assign pull_out = pull_in;
            end
        end
    endgenerate
endmodule

// File: rtl/bscan_chain.sv
// Chain of boundary-scan cells; cell 0 is next to scan_in, the last cell
// drives scan_out. CELL_KIND gives the kind of every position.
// Assumes: strobes come from an external test access controller.
module bscan_chain
    import bsc_pkg::*;
#(
    parameter int unsigned NCELLS = DEF_NCELLS,
    parameter cell_kind_e  CELL_KIND [NCELLS] = DEF_KINDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_dr,
    input  logic              shift_dr,
    input  logic              upd_dr,
    input  logic              test_mode,
    input  logic              scan_in,
    output logic              scan_out,
    input  logic [NCELLS-1:0] func_in,
    output logic [NCELLS-1:0] func_out,
    input  logic [NCELLS-1:0] pull_in,
    output logic [NCELLS-1:0] pull_out
);
    localparam int unsigned LAST = NCELLS - 1;

    logic [NCELLS:0]   link;
    logic [NCELLS-1:0] shift_vec;
    logic [NCELLS-1:0] upd_vec;

    assign link[0] = scan_in;

    generate
        for (genvar i = 0; i < NCELLS; i++) begin : g_cell
            bsc_cell #(.KIND(CELL_KIND[i])) u_cell (
                .clk      (clk),
                .rst_n    (rst_n),
                .cap_en   (cap_dr),
                .shift_en (shift_dr),
                .upd_en   (upd_dr),
                .mode     (test_mode),
                .ser_in   (link[i]),
                .func_in  (func_in[i]),
                .pull_in  (pull_in[i]),
                .ser_out  (link[i+1]),
                .func_out (func_out[i]),
                .pull_out (pull_out[i]),
                .upd_val  (upd_vec[i])
            );
            assign shift_vec[i] = link[i+1];
        end
    endgenerate

    assign scan_out = link[LAST+1];
endmodule

// File: rtl/bscan_chain_chk.sv
// Assertion checker for bscan_chain, attached by bind.
module bscan_chain_chk
    import bsc_pkg::*;
#(
    parameter int unsigned NCELLS = DEF_NCELLS,
    parameter cell_kind_e  CELL_KIND [NCELLS] = DEF_KINDS
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cap_dr,
    input logic              shift_dr,
    input logic              upd_dr,
    input logic              test_mode,
    input logic              scan_in,
    input logic [NCELLS-1:0] func_in,
    input logic [NCELLS-1:0] func_out,
    input logic [NCELLS-1:0] pull_in,
    input logic [NCELLS-1:0] pull_out,
    input logic [NCELLS-1:0] shift_vec,
    input logic [NCELLS-1:0] upd_vec
);
    // R2
    capture_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_dr |=> shift_vec == $past(func_in));

    // R3
    shift_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_dr && !cap_dr) |=> shift_vec[0] == $past(scan_in));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_dr && !cap_dr) |=> $stable(shift_vec));

    // R4
    update_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_dr && $past(rst_n)) |-> $stable(upd_vec));

    // R5
    functional_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !test_mode |-> (func_out == func_in && pull_out == pull_in));

    generate
        for (genvar i = 0; i < NCELLS; i++) begin : g_k
            if (CELL_KIND[i] == KIND_IN_RO) begin : g_ro
                // R7
                readonly_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    func_out[i] == func_in[i]);
            end
            if (CELL_KIND[i] == KIND_OE) begin : g_oe
                // R8
                pull_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    test_mode |-> pull_out[i] == func_out[i]);
            end
        end
    endgenerate
endmodule

bind bscan_chain bscan_chain_chk #(.NCELLS(NCELLS), .CELL_KIND(CELL_KIND)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_dr    (cap_dr),
    .shift_dr  (shift_dr),
    .upd_dr    (upd_dr),
    .test_mode (test_mode),
    .scan_in   (scan_in),
    .func_in   (func_in),
    .func_out  (func_out),
    .pull_in   (pull_in),
    .pull_out  (pull_out),
    .shift_vec (shift_vec),
    .upd_vec   (upd_vec)
);

// File: tb/tb_bscan_chain.sv
module tb_bscan_chain;
    import bsc_pkg::*;

    localparam int unsigned N = DEF_NCELLS;
    localparam time CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n, cap_dr, shift_dr, upd_dr, test_mode, scan_in, scan_out;
    logic [N-1:0] func_in, func_out, pull_in, pull_out;

    int checks = 0;
    int failures = 0;
    logic [N-1:0] model_upd;

    bscan_chain dut (
        .clk(clk), .rst_n(rst_n), .cap_dr(cap_dr), .shift_dr(shift_dr),
        .upd_dr(upd_dr), .test_mode(test_mode), .scan_in(scan_in),
        .scan_out(scan_out), .func_in(func_in), .func_out(func_out),
        .pull_in(pull_in), .pull_out(pull_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic logic [N-1:0] exp_func(input logic m, input logic [N-1:0] fin, input logic [N-1:0] u);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++)
            r[i] = (DEF_KINDS[i] == KIND_IN_RO || !m) ? fin[i] : u[i];
        return r;
    endfunction

    function automatic logic [N-1:0] exp_pull(input logic m, input logic [N-1:0] pin, input logic [N-1:0] u);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++)
            r[i] = (DEF_KINDS[i] == KIND_OE && m) ? u[i] : pin[i];
        return r;
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Shift pat in (cell i ends with pat[i]); returns the bits seen, per cell.
    task automatic shift_all(input logic [N-1:0] pat, output logic [N-1:0] seen);
        shift_dr = 1'b1;
        for (int k = 0; k < N; k++) begin
            scan_in = pat[N-1-k];
            seen[N-1-k] = scan_out;
            step();
        end
        shift_dr = 1'b0;
    endtask

    task automatic do_update(input logic [N-1:0] pat);
        upd_dr = 1'b1;
        step();
        upd_dr = 1'b0;
        for (int i = 0; i < N; i++)
            if (DEF_KINDS[i] != KIND_IN_RO) model_upd[i] = pat[i];
    endtask

    initial begin
        logic [N-1:0] pat, seen, fin, seen_mid;
        void'($urandom(32'd1149));
        rst_n = 1'b0; cap_dr = 0; shift_dr = 0; upd_dr = 0;
        test_mode = 1'b1; scan_in = 0; func_in = '1; pull_in = '1;
        model_upd = '0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1: reset state under test mode
        check("R1 func_out", func_out, exp_func(1'b1, func_in, '0));
        check("R1 pull_out", pull_out, exp_pull(1'b1, pull_in, '0));

        for (int it = 0; it < 24; it++) begin
            pat = (it == 0) ? '1 : (it == 1) ? '0 : N'($urandom);
            func_in = N'($urandom); pull_in = N'($urandom);
            test_mode = 1'b0;
            shift_all(pat, seen);
            // R5: preload leaves pins alone in functional mode
            check("R5 func_out", func_out, func_in);
            do_update(pat);
            check("R5 pull_out", pull_out, pull_in);
            test_mode = 1'b1;
            #1;
            // R6 / R7: pattern replaces the path except on read-only cells
            check("R6 R7 func_out", func_out, exp_func(1'b1, func_in, model_upd));
            // R8: enable cells drive the pull-up disable
            check("R8 pull_out", pull_out, exp_pull(1'b1, pull_in, model_upd));
            // R4: shifting with no update keeps the driven value
            shift_all(~pat, seen_mid);
            check("R4 hold", func_out, exp_func(1'b1, func_in, model_upd));
            // R3: the bits unloaded were those loaded by the shift before
            check("R3 unload", seen_mid, pat);
            // R2: capture the pins and unload them
            fin = N'($urandom);
            func_in = fin;
            cap_dr = 1'b1;
            if (it % 3 == 1) shift_dr = 1'b1;   // R10 both strobes
            step();
            cap_dr = 1'b0; shift_dr = 1'b0;
            if (it % 3 == 2) repeat (4) step(); // R9 idle hold
            func_in = N'($urandom);
            shift_all(N'($urandom), seen);
            if (it % 3 == 1)      check("R10 capture wins", seen, fin);
            else if (it % 3 == 2) check("R9 idle hold", seen, fin);
            else                  check("R2 capture", seen, fin);
        end

        // R1: reset again clears update flops
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
        model_upd = '0;
        step();
        check("R1 after reset", func_out, exp_func(1'b1, func_in, '0));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        failures++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule